// File: doc/BRIEF.md
# Memory-Window SPI Flash Bridge

This block lets a host reach a serial flash chip through plain byte reads and writes to a small address window, with no dedicated SPI controller. Two 256-byte pages inside a 4 KiB window select what happens. Touching the deselect page raises chip-enable and ends the current flash transaction. Touching the select page lowers chip-enable and moves exactly one byte over a mode-0 SPI link. A write sends the host byte. A read returns the byte clocked in from the flash.

The same window can also be reached without a wide host address. A small indirect port holds a 32-bit target address in four byte registers. A fifth register is the data port: an access to it is performed as a window access at the stored address. The stored address bytes persist, so software rewrites only the byte that picks the page when it switches between select and deselect.

While a byte is moving, `ready` is low and the host must wait. Read data is valid in the cycle in which `ready` returns high.

Top module: `ffb_bridge`

## Requirements
- R1: After reset, `spi_cs_n` is 1, `spi_sclk` is 0, `ready` is 1, and all four indirect address bytes read back as 0x00.
- R2: A window access is claimed only when its effective address lies in 0xFFFFF000 to 0xFFFFFFFF. `claim` pulses high for exactly the cycle after a claimed access is accepted. An access outside the window leaves the SPI pins untouched, and a read from outside the window returns 0xFF.
- R3: A write to the deselect page (window offset 0xE00, addresses 0xFFFFFExx) sets `spi_cs_n` to 1 in the cycle after acceptance, whatever the data value. `spi_sclk` stays 0.
- R4: A write to the select page (window offset 0xD00, addresses 0xFFFFFDxx) sets `spi_cs_n` to 0 and sends the written byte on `spi_mosi`, MSB first, in SPI mode 0. Data changes while `spi_sclk` is low and is stable at each rising edge.
- R5: A read from the select page keeps `spi_cs_n` at 0 and drives `spi_mosi` high for all 8 bits. It samples `spi_miso` on each rising `spi_sclk`, MSB first, and places the byte on `rdata` in the cycle in which `ready` returns to 1. `rdata` does not change while `ready` is 0.
- R6: `spi_cs_n` stays 0 across any number of consecutive select-page accesses. It rises only on a deselect-page write.
- R7: With `use_ind` = 1, offsets 0 to 3 are byte registers that form the indirect target address in little-endian order (offset 0 is bits 7:0). Each is readable and keeps its value until it is written again.
- R8: With `use_ind` = 1, a write or read at offset 4 performs the window write or read at the composed indirect address, with the same effect and read data as a direct access to that address.
- R9: Each select-page byte holds `ready` at 0 for exactly 16 × DIV_HALF cycles, starting the cycle after acceptance. Every other access completes with `ready` staying 1. Read data for such an access is on `rdata` in the next cycle.
- R10: A read from the deselect page, or any access to another page of the window, leaves the SPI pins unchanged. Reads of this kind return 0xFF.
- R11: Whenever `spi_cs_n` is 1, `spi_sclk` is 0.
- R12: With `use_ind` = 1, offsets 5 to 7 do nothing. Writes to them change no state, and reads from them return 0xFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req | input | 1 | Access request; accepted in a cycle where `ready` is 1 |
| we | input | 1 | 1 = write, 0 = read |
| use_ind | input | 1 | 1 = indirect port access (offset in `addr[2:0]`), 0 = direct window access |
| addr | input | ADDR_W | Direct address, or indirect register offset in the low bits |
| wdata | input | DATA_W | Write data |
| rdata | output | DATA_W | Read data |
| ready | output | 1 | 1 = idle and able to accept; 0 = a byte is shifting |
| claim | output | 1 | One-cycle pulse for an accepted access inside the window |
| spi_cs_n | output | 1 | Flash chip-enable, active low |
| spi_sclk | output | 1 | SPI clock |
| spi_mosi | output | 1 | Serial data to the flash |
| spi_miso | input | 1 | Serial data from the flash |

## Verification
The properties assume that the host raises `req` only while `ready` is 1 and holds its fields for that single cycle. They also assume that `spi_miso` is driven by a device that changes it only after a rising `spi_sclk`. The stimulus meets both assumptions because it issues every access through one task. That task waits for `ready` at a falling clock edge, pulses `req` for one cycle, and waits again. The flash model presents each bit combinationally from a byte the bench chooses before the access begins.

// File: rtl/ffb_pkg.sv
package ffb_pkg;
  typedef enum logic [1:0] {
    PG_OUTSIDE = 2'd0,
    PG_SELECT  = 2'd1,
    PG_DESEL   = 2'd2,
    PG_OTHER   = 2'd3
  } pg_kind_t;
endpackage

// File: rtl/ffb_win_decode.sv
module ffb_win_decode
  import ffb_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter logic [ADDR_W-1:0] WIN_BASE = 32'hFFFF_F000,
  parameter int WIN_BYTES = 4096,
  parameter int PAGE_BYTES = 256,
  parameter logic [ADDR_W-1:0] SEL_OFS = 32'h0000_0D00,
  parameter logic [ADDR_W-1:0] DESEL_OFS = 32'h0000_0E00
) (
  input  logic [ADDR_W-1:$clog2(PAGE_BYTES)] addr_hi,
  output pg_kind_t kind
);
  localparam int WIN_AW = $clog2(WIN_BYTES);
  localparam int PG_AW = $clog2(PAGE_BYTES);
  localparam int PG_W = WIN_AW - PG_AW;
  localparam logic [ADDR_W-WIN_AW-1:0] BASE_TAG = WIN_BASE[ADDR_W-1:WIN_AW];
  localparam logic [PG_W-1:0] SEL_PG = SEL_OFS[WIN_AW-1:PG_AW];
  localparam logic [PG_W-1:0] DESEL_PG = DESEL_OFS[WIN_AW-1:PG_AW];

  logic in_win;
  logic [PG_W-1:0] pg;

  assign in_win = (addr_hi[ADDR_W-1:WIN_AW] == BASE_TAG);
  assign pg = addr_hi[WIN_AW-1:PG_AW];

  always_comb begin
    if (!in_win)              kind = PG_OUTSIDE;
    else if (pg == SEL_PG)    kind = PG_SELECT;
    else if (pg == DESEL_PG)  kind = PG_DESEL;
    else                      kind = PG_OTHER;
  end
endmodule

// File: rtl/ffb_ind_regs.sv
module ffb_ind_regs #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 8
) (
  input  logic                              clk,
  input  logic                              rst,
  input  logic                              wr_en,
  input  logic [$clog2(ADDR_W/DATA_W)-1:0]  sel,
  input  logic [DATA_W-1:0]                 wdata,
  output logic [ADDR_W-1:0]                 tgt_addr
);
  localparam int NB = ADDR_W / DATA_W;
  localparam int SW = $clog2(NB);

  for (genvar g = 0; g < NB; g++) begin : g_byte
    always_ff @(posedge clk) begin
      if (rst)
        tgt_addr[g*DATA_W +: DATA_W] <= '0;
      else if (wr_en && sel == SW'(g))
        tgt_addr[g*DATA_W +: DATA_W] <= wdata;
    end
  end
endmodule

// File: rtl/ffb_spi_byte.sv
module ffb_spi_byte #(
  parameter int DATA_W = 8,
  parameter int DIV_HALF = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [DATA_W-1:0] tx,
  input  logic              miso,
  output logic              sclk,
  output logic              mosi,
  output logic              idle,
  output logic              fin,
  output logic [DATA_W-1:0] rx
);
  localparam int CW = $clog2(DIV_HALF) + 1;
  localparam int BW = $clog2(DATA_W);

  logic              busy;
  logic              sclk_q;
  logic [CW-1:0]     cnt;
  logic [BW-1:0]     bitn;
  logic [DATA_W-1:0] txs;
  logic [DATA_W-1:0] rxs;
  logic              tick;

  assign tick = busy && (cnt == CW'(DIV_HALF - 1));
  assign fin  = tick && sclk_q && (bitn == BW'(DATA_W - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      busy   <= 1'b0;
      sclk_q <= 1'b0;
      cnt    <= '0;
      bitn   <= '0;
      txs    <= '0;
      rxs    <= '0;
    end else if (!busy) begin
      if (start) begin
        busy   <= 1'b1;
        sclk_q <= 1'b0;
        cnt    <= '0;
        bitn   <= '0;
        txs    <= tx;
      end
    end else if (tick) begin
      cnt <= '0;
      if (!sclk_q) begin
        sclk_q <= 1'b1;
        rxs    <= {rxs[DATA_W-2:0], miso};
      end else begin
        sclk_q <= 1'b0;
        if (bitn == BW'(DATA_W - 1)) begin
          busy <= 1'b0;
        end else begin
          bitn <= bitn + 1'b1;
          txs  <= {txs[DATA_W-2:0], 1'b0};
        end
      end
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  assign sclk = sclk_q;
  assign mosi = txs[DATA_W-1];
  assign idle = !busy;
  assign rx   = rxs;
endmodule

// File: rtl/ffb_bridge.sv
module ffb_bridge
  import ffb_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 8,
  parameter logic [ADDR_W-1:0] WIN_BASE = 32'hFFFF_F000,
  parameter int WIN_BYTES = 4096,
  parameter int PAGE_BYTES = 256,
  parameter logic [ADDR_W-1:0] SEL_OFS = 32'h0000_0D00,
  parameter logic [ADDR_W-1:0] DESEL_OFS = 32'h0000_0E00,
  parameter int DIV_HALF = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req,
  input  logic              we,
  input  logic              use_ind,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              ready,
  output logic              claim,
  output logic              spi_cs_n,
  output logic              spi_sclk,
  output logic              spi_mosi,
  input  logic              spi_miso
);
  localparam int NB = ADDR_W / DATA_W;
  localparam int SW = $clog2(NB);
  localparam int OFS_W = SW + 1;
  localparam int PG_AW = $clog2(PAGE_BYTES);
  localparam logic [OFS_W-1:0] DATA_OFS = OFS_W'(NB);

  logic [OFS_W-1:0]  ofs;
  logic              ind_reg_hit;
  logic              win_op;
  logic              accept;
  logic              start;
  logic [ADDR_W-1:0] ind_addr;
  logic [ADDR_W-1:0] eff_addr;
  logic [DATA_W-1:0] ind_byte;
  logic [DATA_W-1:0] tx_byte;
  logic [DATA_W-1:0] rx_byte;
  logic              sh_idle;
  logic              sh_fin;
  logic              rd_pend;
  pg_kind_t          kind;

  assign ofs         = addr[OFS_W-1:0];
  assign ind_reg_hit = use_ind && (ofs < DATA_OFS);
  assign win_op      = !use_ind || (ofs == DATA_OFS);
  assign accept      = req && sh_idle;
  assign eff_addr    = use_ind ? ind_addr : addr;
  assign ind_byte    = ind_addr[ofs[SW-1:0]*DATA_W +: DATA_W];
  assign start       = accept && win_op && (kind == PG_SELECT);
  assign tx_byte     = we ? wdata : '1;

  ffb_win_decode #(
    .ADDR_W(ADDR_W), .WIN_BASE(WIN_BASE), .WIN_BYTES(WIN_BYTES),
    .PAGE_BYTES(PAGE_BYTES), .SEL_OFS(SEL_OFS), .DESEL_OFS(DESEL_OFS)
  ) u_dec (
    .addr_hi (eff_addr[ADDR_W-1:PG_AW]),
    .kind    (kind)
  );

  ffb_ind_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ind (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (accept && ind_reg_hit && we),
    .sel      (ofs[SW-1:0]),
    .wdata    (wdata),
    .tgt_addr (ind_addr)
  );

  ffb_spi_byte #(.DATA_W(DATA_W), .DIV_HALF(DIV_HALF)) u_sh (
    .clk   (clk),
    .rst   (rst),
    .start (start),
    .tx    (tx_byte),
    .miso  (spi_miso),
    .sclk  (spi_sclk),
    .mosi  (spi_mosi),
    .idle  (sh_idle),
    .fin   (sh_fin),
    .rx    (rx_byte)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      spi_cs_n <= 1'b1;
      claim    <= 1'b0;
      rdata    <= '1;
      rd_pend  <= 1'b0;
    end else begin
      claim <= accept && win_op && (kind != PG_OUTSIDE);
      if (start) begin
        spi_cs_n <= 1'b0;
        rd_pend  <= !we;
      end
      if (accept && win_op && kind == PG_DESEL && we)
        spi_cs_n <= 1'b1;
      if (accept && !we) begin
        if (ind_reg_hit)
          rdata <= ind_byte;
        else if (!start)
          rdata <= '1;
      end
      if (sh_fin) begin
        if (rd_pend)
          rdata <= rx_byte;
        rd_pend <= 1'b0;
      end
    end
  end

  assign ready = sh_idle;
endmodule

// File: rtl/ffb_bridge_chk.sv
module ffb_bridge_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              req,
  input logic              we,
  input logic [DATA_W-1:0] rdata,
  input logic              ready,
  input logic              claim,
  input logic              spi_cs_n,
  input logic              spi_sclk
);
  p_sclk_idle_r11: assert property (@(posedge clk) disable iff (rst)
    spi_cs_n |-> !spi_sclk);

  p_busy_selected_r6: assert property (@(posedge clk) disable iff (rst)
    !ready |-> !spi_cs_n);

  p_cs_rise_r3: assert property (@(posedge clk) disable iff (rst)
    $rose(spi_cs_n) |-> ($past(req) && $past(we) && $past(ready)));

  p_cs_fall_r4: assert property (@(posedge clk) disable iff (rst)
    $fell(spi_cs_n) |-> ($past(req) && $past(ready)));

  p_claim_pulse_r2: assert property (@(posedge clk) disable iff (rst)
    claim |-> ($past(req) && $past(ready)));

  p_rdata_hold_r5: assert property (@(posedge clk) disable iff (rst)
    !ready |-> $stable(rdata));

  p_sclk_busy_r9: assert property (@(posedge clk) disable iff (rst)
    !$stable(spi_sclk) |-> !$past(ready));
endmodule

bind ffb_bridge ffb_bridge_chk #(.DATA_W(DATA_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .req      (req),
  .we       (we),
  .rdata    (rdata),
  .ready    (ready),
  .claim    (claim),
  .spi_cs_n (spi_cs_n),
  .spi_sclk (spi_sclk)
);

// File: tb/sim_ffb_bridge.sv
module sim_ffb_bridge;
  localparam int DIV = 2;
  localparam int STALL = 16 * DIV;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req = 1'b0;
  logic        we = 1'b0;
  logic        use_ind = 1'b0;
  logic [31:0] addr = '0;
  logic [7:0]  wdata = '0;
  logic [7:0]  rdata;
  logic        ready;
  logic        claim;
  logic        spi_cs_n;
  logic        spi_sclk;
  logic        spi_mosi;
  logic        spi_miso;

  always #4 clk = ~clk;

  ffb_bridge #(.DIV_HALF(DIV)) u0 (
    .clk(clk), .rst(rst), .req(req), .we(we), .use_ind(use_ind),
    .addr(addr), .wdata(wdata), .rdata(rdata), .ready(ready),
    .claim(claim), .spi_cs_n(spi_cs_n), .spi_sclk(spi_sclk),
    .spi_mosi(spi_mosi), .spi_miso(spi_miso)
  );

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // flash model: presents bits from slave_next, records bytes seen on MOSI
  logic [7:0] slave_next = 8'hA5;
  logic [2:0] bitc = 3'd0;
  logic [7:0] srx = 8'h00;
  logic [7:0] last_mosi = 8'h00;
  int         nbytes = 0;
  assign spi_miso = slave_next[3'd7 - bitc];

  always @(posedge spi_sclk) begin
    srx = {srx[6:0], spi_mosi};
    if (bitc == 3'd7) begin
      last_mosi = srx;
      nbytes++;
      bitc = 3'd0;
    end else begin
      bitc = bitc + 3'd1;
    end
  end

  // cycle reference model
  int         m_busy;
  logic       m_csn;
  logic       m_claim;
  logic [7:0] m_ind [4];

  always @(posedge clk) begin
    if (rst) begin
      m_busy = 0; m_csn = 1'b1; m_claim = 1'b0;
      for (int i = 0; i < 4; i++) m_ind[i] = 8'h00;
    end else begin
      m_claim = 1'b0;
      if (m_busy > 0) m_busy--;
      else if (req) begin
        logic [31:0] ea;
        if (use_ind && addr[2:0] < 3'd4 && we) m_ind[addr[1:0]] = wdata;
        if (!use_ind || addr[2:0] == 3'd4) begin
          ea = use_ind ? {m_ind[3], m_ind[2], m_ind[1], m_ind[0]} : addr;
          if (ea[31:12] == 20'hFFFFF) begin
            m_claim = 1'b1;
            if (ea[11:8] == 4'hD) begin
              m_busy = STALL; m_csn = 1'b0;
            end else if (ea[11:8] == 4'hE && we) begin
              m_csn = 1'b1;
            end
          end
        end
      end
    end
  end

  always @(negedge clk) begin
    if (!rst && !finished) begin
      chk("R9 ready vs model", ready, (m_busy == 0));
      chk("R6 cs_n vs model", spi_cs_n, m_csn);
      chk("R2 claim vs model", claim, m_claim);
      chk("R11 sclk low while deselected", spi_cs_n ? spi_sclk : 1'b0, 1'b0);
    end
  end

  int  stall;
  bit  clm;

  task automatic acc(input bit ind, input bit w, input logic [31:0] a, input logic [7:0] d);
    @(negedge clk);
    while (!ready) @(negedge clk);
    req = 1'b1; use_ind = ind; we = w; addr = a; wdata = d;
    @(negedge clk);
    req = 1'b0;
    clm = claim;
    stall = 0;
    while (!ready) begin
      stall++;
      @(negedge clk);
    end
  endtask

  initial begin
    int nb;
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 1'b0;
    @(negedge clk);
    chk("R1 cs_n after reset", spi_cs_n, 1'b1);
    chk("R1 sclk after reset", spi_sclk, 1'b0);
    chk("R1 ready after reset", ready, 1'b1);
    for (int i = 0; i < 4; i++) begin
      acc(1'b1, 1'b0, 32'(i), 8'h00);
      chk("R1 indirect byte zero", rdata, 8'h00);
    end

    // direct select-page write
    acc(1'b0, 1'b1, 32'hFFFF_FD00, 8'h3C);
    chk("R4 mosi byte", last_mosi, 8'h3C);
    chk("R4 cs_n low", spi_cs_n, 1'b0);
    chk("R9 stall length", stall, STALL);
    chk("R2 claim in window", clm, 1'b1);

    // direct select-page reads
    slave_next = 8'h96;
    acc(1'b0, 1'b0, 32'hFFFF_FD00, 8'h00);
    chk("R5 read data", rdata, 8'h96);
    chk("R5 mosi all ones on read", last_mosi, 8'hFF);
    slave_next = 8'h5A;
    acc(1'b0, 1'b0, 32'hFFFF_FD7F, 8'h00);
    chk("R5 second read data", rdata, 8'h5A);
    chk("R6 cs_n held low", spi_cs_n, 1'b0);

    // deselect
    acc(1'b0, 1'b1, 32'hFFFF_FE10, 8'h00);
    chk("R3 cs_n high after deselect write", spi_cs_n, 1'b1);
    chk("R3 sclk low", spi_sclk, 1'b0);
    chk("R9 no stall for deselect", stall, 0);

    // other pages and deselect read
    nb = nbytes;
    acc(1'b0, 1'b0, 32'hFFFF_FE00, 8'h00);
    chk("R10 deselect read data", rdata, 8'hFF);
    acc(1'b0, 1'b1, 32'hFFFF_F100, 8'h77);
    chk("R10 other page write no SPI byte", nbytes, nb);
    chk("R10 cs_n unchanged", spi_cs_n, 1'b1);
    acc(1'b0, 1'b0, 32'hFFFF_F000, 8'h00);
    chk("R10 other page read", rdata, 8'hFF);

    // select, then hit an outside address
    acc(1'b0, 1'b1, 32'hFFFF_FD00, 8'hA1);
    nb = nbytes;
    acc(1'b0, 1'b1, 32'h1234_5D00, 8'h11);
    chk("R2 outside not claimed", clm, 1'b0);
    chk("R2 outside no SPI byte", nbytes, nb);
    chk("R2 outside cs_n unchanged", spi_cs_n, 1'b0);
    acc(1'b0, 1'b0, 32'h0000_0D00, 8'h00);
    chk("R2 outside read data", rdata, 8'hFF);
    acc(1'b0, 1'b1, 32'hFFFF_FE00, 8'h5F);
    chk("R3 cs_n high", spi_cs_n, 1'b1);

    // indirect registers
    acc(1'b1, 1'b1, 32'd0, 8'h00);
    acc(1'b1, 1'b1, 32'd1, 8'hFD);
    acc(1'b1, 1'b1, 32'd2, 8'hFF);
    acc(1'b1, 1'b1, 32'd3, 8'hFF);
    acc(1'b1, 1'b0, 32'd1, 8'h00);
    chk("R7 offset1 readback", rdata, 8'hFD);
    acc(1'b1, 1'b0, 32'd3, 8'h00);
    chk("R7 offset3 readback", rdata, 8'hFF);
    acc(1'b1, 1'b1, 32'd4, 8'hC3);
    chk("R8 indirect write byte", last_mosi, 8'hC3);
    chk("R8 indirect write cs_n", spi_cs_n, 1'b0);
    chk("R8 indirect claim", clm, 1'b1);
    slave_next = 8'h71;
    acc(1'b1, 1'b0, 32'd4, 8'h00);
    chk("R8 indirect read data", rdata, 8'h71);
    acc(1'b1, 1'b1, 32'd1, 8'hFE);
    acc(1'b1, 1'b1, 32'd4, 8'h00);
    chk("R8 indirect deselect", spi_cs_n, 1'b1);
    acc(1'b1, 1'b0, 32'd0, 8'h00);
    chk("R7 offset0 kept", rdata, 8'h00);
    acc(1'b1, 1'b0, 32'd2, 8'h00);
    chk("R7 offset2 kept", rdata, 8'hFF);

    // unused indirect offsets
    acc(1'b1, 1'b1, 32'd5, 8'h55);
    acc(1'b1, 1'b0, 32'd5, 8'h00);
    chk("R12 offset5 read", rdata, 8'hFF);
    acc(1'b1, 1'b1, 32'd7, 8'h0D);
    acc(1'b1, 1'b0, 32'd1, 8'h00);
    chk("R12 offset1 untouched", rdata, 8'hFE);
    acc(1'b1, 1'b0, 32'd3, 8'h00);
    chk("R12 offset3 untouched", rdata, 8'hFF);
    chk("R12 cs_n unchanged", spi_cs_n, 1'b1);

    repeat (4) @(negedge clk);
    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(8 * 150000);
    if (!finished) begin
      finished = 1'b1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("[TB] %0d tests run, %0d failed", n_chk, n_bad);
      $finish;
    end
  end
endmodule